// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, for each incoming frame, whether the receive path should keep it. It watches the destination address bytes as they arrive after a start-of-frame strobe. It keeps a running CRC-32 over those six bytes, compares them with the programmed station address and looks up a 64-bit group hash table. At the end-of-frame strobe it combines the address result with the frame length, the CRC and alignment error flags and a set of configuration enables. It then registers one decision: accept or reject, plus a flag that says whether the destination was an individual or a group address.

Two hash bins have a second use. When remote transmitter control is enabled, an error-free group frame whose hash lands in bin 62 raises a one-cycle request to disable the local transmitter. A frame that lands in bin 63 raises a one-cycle request to enable it again. The CRC over the payload is checked elsewhere; this block only receives the resulting error flag.

Top module: `rx_addr_filter`

## Requirements
- R1: An individual destination (bit 0 of the first received byte is 0) is accepted only if all six bytes equal `station_addr`. The first received byte is compared with `station_addr[7:0]` and the sixth with `station_addr[47:40]`.
- R2: With `cfg_promisc` set, every individual destination is accepted, whatever the station address.
- R3: The all-ones destination is accepted only when `cfg_bcast_en` is 1. The hash table has no effect on it.
- R4: A group destination other than all-ones is accepted only when `cfg_mcast_en` is 1 and `hash_table[idx]` is 1. `idx` is the top six bits `[31:26]` of a CRC-32 register (polynomial 0x04C11DB7, preset all ones, shifted toward the MSB, data bits fed LSB first, no final inversion) after the six destination bytes.
- R5: `group_hit` is 1 when bit 0 of the first destination byte is 1, which covers multicast and broadcast. It is 0 for an individual destination.
- R6: A frame with `frame_len` below 64 is rejected unless `cfg_runt_en` is 1. A length of exactly 64 is not a runt.
- R7: A frame with `crc_err` or `align_err` set at end-of-frame is rejected unless `cfg_keep_err` is 1.
- R8: `dec_valid`, `accept` and `group_hit` are updated by the clock edge that samples `eof`. They hold until the edge that samples the next `sof`, which clears `dec_valid` and `accept`.
- R9: A frame that ends with fewer than six destination bytes is rejected. Bytes after the sixth do not affect the decision or the hash.
- R10: With `cfg_auto_txoff` set, an error-free, non-broadcast group frame hashing to bin 62 pulses `tx_disable_req`, and one hashing to bin 63 pulses `tx_enable_req`. Each pulse lasts exactly one cycle and comes together with the decision. It does not depend on `cfg_mcast_en`, the table or the length. There are no pulses when `cfg_auto_txoff` is 0.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sof | input | 1 | Start of frame strobe; a byte may arrive in the same cycle |
| byte_vld | input | 1 | `byte_data` carries a received byte |
| byte_data | input | 8 | Received byte, destination address first |
| eof | input | 1 | End of frame strobe |
| frame_len | input | 16 | Frame length in bytes, valid with `eof` |
| crc_err | input | 1 | Frame CRC error, valid with `eof` |
| align_err | input | 1 | Frame alignment error, valid with `eof` |
| cfg_promisc | input | 1 | Accept all individual destinations |
| cfg_bcast_en | input | 1 | Accept the all-ones destination |
| cfg_mcast_en | input | 1 | Accept group destinations through the hash table |
| cfg_runt_en | input | 1 | Keep frames shorter than 64 bytes |
| cfg_keep_err | input | 1 | Keep frames with CRC or alignment errors |
| cfg_auto_txoff | input | 1 | Enable remote transmitter control through bins 62 and 63 |
| station_addr | input | 48 | Station address, first byte in bits 7:0 |
| hash_table | input | 64 | Group hash filter, bit n for bin n |
| dec_valid | output | 1 | A decision is present |
| accept | output | 1 | Frame accepted |
| group_hit | output | 1 | Destination was a group address |
| tx_disable_req | output | 1 | One-cycle request to disable the transmitter |
| tx_enable_req | output | 1 | One-cycle request to enable the transmitter |

## Verification
The transmitter control requests and the accept decision are produced in the same cycle, from the same hash index. A frame that hashes to bin 62 or 63 is therefore sent with the group filter open, and again with it closed. The bench then checks that `accept` follows the table and enable while the request pulse appears anyway. It also checks that the pulse falls one cycle later while the decision is held. Addresses that land in bins 62 and 63 are found by a search in the bench with its own hash routine, so the overlap is reached on purpose and not by luck.

// File: rtl/rx_af_pkg.sv
// Package for the receive address filter.
// Holds the configuration bundle and the hash CRC step shared by the design.
package rx_af_pkg;

    // Receive configuration enables, gathered at the top.
    typedef struct packed {
        logic promisc;
        logic bcast_en;
        logic mcast_en;
        logic runt_en;
        logic keep_err;
        logic auto_txoff;
    } rx_af_cfg_t;

    localparam logic [31:0] CRC_POLY   = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_PRESET = 32'hFFFF_FFFF;

    // Fold one byte, LSB first, into an MSB-shifting CRC-32 register.
    function automatic logic [31:0] crc_fold(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[31] ^ d[i]) r = (r << 1) ^ CRC_POLY;
            else              r = r << 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/rx_af_capture.sv
// Destination address capture.
// Counts the bytes after a start-of-frame strobe and keeps the first
// ADDR_BYTES of them, the first byte in the low byte lane.
// Assumes: sof restarts the count; a byte given together with sof is the
// first address byte; later bytes are ignored.
module rx_af_capture #(
    parameter int ADDR_BYTES = 6,
    localparam int AW = ADDR_BYTES * 8,
    localparam int CW = $clog2(ADDR_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sof,
    input  logic          byte_vld,
    input  logic [7:0]    byte_data,
    output logic          take,
    output logic [AW-1:0] dest,
    output logic          addr_done
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] slot;

    // Slot the incoming byte belongs to; sof restarts at zero.
    assign slot      = sof ? '0 : cnt_q;
    assign take      = byte_vld && (slot < CW'(ADDR_BYTES));
    assign addr_done = (cnt_q == CW'(ADDR_BYTES));

    // Byte counter, saturating once the address is complete.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (take)   cnt_q <= slot + CW'(1);
        else if (sof)    cnt_q <= '0;
    end

    // Address register, one byte lane per slot.
    always_ff @(posedge clk) begin
        if (!rst_n)    dest <= '0;
        else if (take) dest[slot*8 +: 8] <= byte_data;
    end

    // R9: the counter never passes the address length.
    a_r9_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(ADDR_BYTES));

endmodule

// File: rtl/rx_af_hash.sv
// Destination hash generator.
// Runs CRC-32 over the bytes accepted by the capture stage and gives the
// top HASH_BITS of the register as the table index.
// Assumes: 'take' is only high for the address bytes of the current frame.
module rx_af_hash #(
    parameter int HASH_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sof,
    input  logic                 take,
    input  logic [7:0]           byte_data,
    output logic [HASH_BITS-1:0] hash_idx
);
    import rx_af_pkg::*;

    logic [31:0] crc_q;
    logic [31:0] base;

    // A new frame starts from the preset value.
    assign base = sof ? CRC_PRESET : crc_q;

    // CRC register: fold accepted bytes, preset on sof.
    always_ff @(posedge clk) begin
        if (!rst_n)    crc_q <= CRC_PRESET;
        else if (take) crc_q <= crc_fold(base, byte_data);
        else if (sof)  crc_q <= CRC_PRESET;
    end

    assign hash_idx = crc_q[31 -: HASH_BITS];

    // R4: a frame start with no byte leaves the register at its preset.
    a_r4_preset_on_sof: assert property (@(posedge clk) disable iff (!rst_n)
        (sof && !take) |=> (crc_q == CRC_PRESET));

endmodule

// File: rtl/rx_af_decide.sv
// Frame decision stage.
// Combines the captured address, the hash lookup, length and error flags
// with the receive enables at end of frame and holds the result until the
// next frame starts. Also issues the remote transmitter control pulses.
// Assumes: sof and eof never fall in the same cycle.
module rx_af_decide #(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BITS  = 6,
    parameter int LEN_W      = 16,
    parameter int MIN_LEN    = 64,
    localparam int AW        = ADDR_BYTES * 8,
    localparam int NBINS     = 1 << HASH_BITS,
    localparam logic [HASH_BITS-1:0] BIN_OFF = HASH_BITS'(NBINS - 2),
    localparam logic [HASH_BITS-1:0] BIN_ON  = HASH_BITS'(NBINS - 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sof,
    input  logic                  eof,
    input  logic [LEN_W-1:0]      frame_len,
    input  logic                  crc_err,
    input  logic                  align_err,
    input  rx_af_pkg::rx_af_cfg_t cfg,
    input  logic [AW-1:0]         station,
    input  logic [NBINS-1:0]      table_bits,
    input  logic [AW-1:0]         dest,
    input  logic                  addr_done,
    input  logic [HASH_BITS-1:0]  hash_idx,
    output logic                  dec_valid,
    output logic                  accept,
    output logic                  group_hit,
    output logic                  tx_off,
    output logic                  tx_on
);
    logic [ADDR_BYTES-1:0] lane_eq;
    logic is_group, is_bcast, any_err;
    logic phys_hit, bcast_hit, mcast_hit, len_ok, err_ok, acc_d;
    logic remote_cmd;

    // Per-lane station compare.
    for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_lane
        assign lane_eq[b] = (dest[b*8 +: 8] == station[b*8 +: 8]);
    end

    // Address class and filter outcome.
    always_comb begin
        is_group   = dest[0];
        is_bcast   = &dest;
        any_err    = crc_err | align_err;
        phys_hit   = !is_group && (cfg.promisc || (&lane_eq));
        bcast_hit  = is_bcast && cfg.bcast_en;
        mcast_hit  = is_group && !is_bcast && cfg.mcast_en && table_bits[hash_idx];
        len_ok     = cfg.runt_en || (frame_len >= LEN_W'(MIN_LEN));
        err_ok     = cfg.keep_err || !any_err;
        acc_d      = addr_done && (phys_hit || bcast_hit || mcast_hit) && len_ok && err_ok;
        remote_cmd = cfg.auto_txoff && addr_done && is_group && !is_bcast && !any_err;
    end

    // Decision register: loaded at eof, cleared at sof, otherwise held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
            accept    <= 1'b0;
            group_hit <= 1'b0;
        end else if (eof) begin
            dec_valid <= 1'b1;
            accept    <= acc_d;
            group_hit <= is_group;
        end else if (sof) begin
            dec_valid <= 1'b0;
            accept    <= 1'b0;
        end
    end

    // Transmitter control pulses, one cycle wide.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_off <= 1'b0;
            tx_on  <= 1'b0;
        end else begin
            tx_off <= eof && remote_cmd && (hash_idx == BIN_OFF);
            tx_on  <= eof && remote_cmd && (hash_idx == BIN_ON);
        end
    end

    // R8: a decision is present after every end of frame.
    a_r8_valid_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
        eof |=> dec_valid);
    // R8: the decision holds while no frame boundary arrives.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !sof && !eof) |=> ($stable(accept) && $stable(group_hit) && dec_valid));
    // R8: accept only appears with a valid decision.
    a_r8_accept_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> dec_valid);
    // R6: a short frame without runt permission is never kept.
    a_r6_runt_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (eof && !cfg.runt_en && (frame_len < LEN_W'(MIN_LEN))) |=> !accept);
    // R7: an errored frame without keep permission is never kept.
    a_r7_err_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (eof && !cfg.keep_err && (crc_err || align_err)) |=> !accept);
    // R10: the two requests are exclusive, single-cycle and tied to a decision.
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_off, tx_on}));
    a_r10_with_decision: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_off || tx_on) |-> (dec_valid && $rose(dec_valid)));
    a_r10_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.auto_txoff |=> !(tx_off || tx_on));

endmodule

// File: rtl/rx_addr_filter.sv
// Receive address filter, top level.
// Captures the destination address, hashes it and registers an
// accept/reject decision with a group flag at end of frame; bins 62 and 63
// of the hash also drive remote transmitter disable/enable requests.
// Assumes: address bytes come first after sof; eof arrives after the last
// byte of the frame and never with sof.
module rx_addr_filter #(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BITS  = 6,
    parameter int LEN_W      = 16,
    parameter int MIN_LEN    = 64,
    localparam int AW        = ADDR_BYTES * 8,
    localparam int NBINS     = 1 << HASH_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic             byte_vld,
    input  logic [7:0]       byte_data,
    input  logic             eof,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             crc_err,
    input  logic             align_err,
    input  logic             cfg_promisc,
    input  logic             cfg_bcast_en,
    input  logic             cfg_mcast_en,
    input  logic             cfg_runt_en,
    input  logic             cfg_keep_err,
    input  logic             cfg_auto_txoff,
    input  logic [AW-1:0]    station_addr,
    input  logic [NBINS-1:0] hash_table,
    output logic             dec_valid,
    output logic             accept,
    output logic             group_hit,
    output logic             tx_disable_req,
    output logic             tx_enable_req
);
    import rx_af_pkg::*;

    rx_af_cfg_t           cfg;
    logic                 take;
    logic [AW-1:0]        dest;
    logic                 addr_done;
    logic [HASH_BITS-1:0] hash_idx;

    // Bundle the configuration pins.
    assign cfg = '{promisc: cfg_promisc, bcast_en: cfg_bcast_en,
                   mcast_en: cfg_mcast_en, runt_en: cfg_runt_en,
                   keep_err: cfg_keep_err, auto_txoff: cfg_auto_txoff};

    rx_af_capture #(.ADDR_BYTES(ADDR_BYTES)) u_capture (
        .clk(clk), .rst_n(rst_n), .sof(sof), .byte_vld(byte_vld),
        .byte_data(byte_data), .take(take), .dest(dest), .addr_done(addr_done)
    );

    rx_af_hash #(.HASH_BITS(HASH_BITS)) u_hash (
        .clk(clk), .rst_n(rst_n), .sof(sof), .take(take),
        .byte_data(byte_data), .hash_idx(hash_idx)
    );

    rx_af_decide #(
        .ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS),
        .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)
    ) u_decide (
        .clk(clk), .rst_n(rst_n), .sof(sof), .eof(eof),
        .frame_len(frame_len), .crc_err(crc_err), .align_err(align_err),
        .cfg(cfg), .station(station_addr), .table_bits(hash_table),
        .dest(dest), .addr_done(addr_done), .hash_idx(hash_idx),
        .dec_valid(dec_valid), .accept(accept), .group_hit(group_hit),
        .tx_off(tx_disable_req), .tx_on(tx_enable_req)
    );

    // R11: the first cycle after reset shows no decision and no request.
    a_r11_reset_quiet: assert property (@(posedge clk)
        $rose(rst_n) |-> !(dec_valid || accept || tx_disable_req || tx_enable_req));

endmodule

// File: tb/test_rx_addr_filter.sv
// Directed bench for the receive address filter.
module test_rx_addr_filter;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sof = 0, byte_vld = 0, eof = 0, crc_err = 0, align_err = 0;
    logic [7:0]  byte_data = 0;
    logic [15:0] frame_len = 0;
    logic c_pro = 0, c_bc = 0, c_mc = 0, c_runt = 0, c_keep = 0, c_atd = 0;
    logic [47:0] station = 48'h5544_3322_1100;
    logic [63:0] table_v = '0;
    logic dec_valid, accept, group_hit, tx_dis, tx_en;

    int n_checks = 0, n_fail = 0;
    logic mid_valid;
    logic [47:0] mc_a, mc_b, mc_off, mc_on;
    int ia;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_addr_filter i_rx_addr_filter (
        .clk(clk), .rst_n(rst_n), .sof(sof), .byte_vld(byte_vld),
        .byte_data(byte_data), .eof(eof), .frame_len(frame_len),
        .crc_err(crc_err), .align_err(align_err), .cfg_promisc(c_pro),
        .cfg_bcast_en(c_bc), .cfg_mcast_en(c_mc), .cfg_runt_en(c_runt),
        .cfg_keep_err(c_keep), .cfg_auto_txoff(c_atd), .station_addr(station),
        .hash_table(table_v), .dec_valid(dec_valid), .accept(accept),
        .group_hit(group_hit), .tx_disable_req(tx_dis), .tx_enable_req(tx_en)
    );

    // Hash bin from a right-shifting (reflected) CRC, bits reversed back.
    function automatic int bin_of(input logic [47:0] a);
        logic [31:0] r = 32'hFFFF_FFFF;
        int idx = 0;
        for (int k = 0; k < 6; k++)
            for (int i = 0; i < 8; i++)
                r = (r[0] ^ a[k*8+i]) ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
        for (int j = 0; j < 6; j++) idx = idx | (int'(r[j]) << (5 - j));
        return idx;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // One frame: sof, nb bytes of dest (extra bytes are filler), eof.
    // Returns at the falling edge after the eof edge.
    task automatic frame(input logic [47:0] d, input int nb, input int len,
                         input logic ce, input logic ae);
        @(negedge clk) sof = 1;
        @(negedge clk) sof = 0;
        mid_valid = dec_valid;
        for (int i = 0; i < nb; i++) begin
            byte_vld = 1;
            byte_data = (i < 6) ? d[i*8 +: 8] : 8'hA5 ^ 8'(i);
            @(negedge clk);
        end
        byte_vld = 0;
        eof = 1; frame_len = 16'(len); crc_err = ce; align_err = ae;
        @(negedge clk) eof = 0; crc_err = 0; align_err = 0;
    endtask

    task automatic expect_dec(input string req, input logic acc, input logic grp);
        check({req, " valid"}, dec_valid, 1'b1);
        check({req, " accept"}, accept, acc);
        check({req, " group"}, group_hit, grp);
    endtask

    task automatic t_reset;  // R11
        check("R11 dec_valid", dec_valid, 0);
        check("R11 accept", accept, 0);
        check("R11 group", group_hit, 0);
        check("R11 tx_dis", tx_dis, 0);
        check("R11 tx_en", tx_en, 0);
    endtask

    task automatic t_unicast;  // R1 R5
        frame(station, 6, 100, 0, 0);
        expect_dec("R1 match", 1, 0);
        frame(station ^ 48'h0100_0000_0000, 6, 100, 0, 0);
        expect_dec("R1 last byte differs", 0, 0);
        frame(station ^ 48'h0000_0000_0200, 6, 100, 0, 0);
        expect_dec("R5 R1 second byte differs", 0, 0);
    endtask

    task automatic t_promisc;  // R2
        c_pro = 1;
        frame(48'h0A0B_0C0D_0E10, 6, 100, 0, 0);
        expect_dec("R2 any individual", 1, 0);
        c_pro = 0;
        frame(48'h0A0B_0C0D_0E10, 6, 100, 0, 0);
        expect_dec("R2 off", 0, 0);
    endtask

    task automatic t_bcast;  // R3
        table_v = '1; c_mc = 1;
        frame('1, 6, 100, 0, 0);
        expect_dec("R3 bcast disabled", 0, 1);
        c_bc = 1; table_v = '0; c_mc = 0;
        frame('1, 6, 100, 0, 0);
        expect_dec("R3 bcast enabled", 1, 1);
        c_bc = 0;
    endtask

    task automatic t_mcast;  // R4 R5
        table_v = 64'd1 << ia;
        c_mc = 1;
        frame(mc_a, 6, 100, 0, 0);
        expect_dec("R4 bin set", 1, 1);
        frame(mc_b, 6, 100, 0, 0);
        expect_dec("R4 bin clear", 0, 1);
        c_mc = 0;
        frame(mc_a, 6, 100, 0, 0);
        expect_dec("R4 mcast disabled", 0, 1);
        c_pro = 1;
        frame(mc_a, 6, 100, 0, 0);
        expect_dec("R5 promisc no group effect", 0, 1);
        c_pro = 0;
    endtask

    task automatic t_runt;  // R6
        frame(station, 6, 63, 0, 0);
        expect_dec("R6 63 bytes", 0, 0);
        frame(station, 6, 64, 0, 0);
        expect_dec("R6 64 bytes", 1, 0);
        c_runt = 1;
        frame(station, 6, 20, 0, 0);
        expect_dec("R6 runt kept", 1, 0);
        c_runt = 0;
    endtask

    task automatic t_errors;  // R7
        frame(station, 6, 100, 1, 0);
        expect_dec("R7 crc", 0, 0);
        frame(station, 6, 100, 0, 1);
        expect_dec("R7 align", 0, 0);
        c_keep = 1;
        frame(station, 6, 100, 1, 1);
        expect_dec("R7 kept", 1, 0);
        c_keep = 0;
    endtask

    task automatic t_timing;  // R8
        frame(station, 6, 100, 0, 0);
        check("R8 cleared by sof", mid_valid, 0);
        @(negedge clk);
        check("R8 held valid", dec_valid, 1);
        check("R8 held accept", accept, 1);
        @(negedge clk) sof = 1;
        @(negedge clk) sof = 0;
        check("R8 accept cleared", accept, 0);
        check("R8 valid cleared", dec_valid, 0);
    endtask

    task automatic t_short;  // R9
        frame(station, 5, 100, 0, 0);
        expect_dec("R9 five bytes", 0, 0);
        frame(station, 9, 100, 0, 0);
        expect_dec("R9 extra bytes", 1, 0);
        table_v = 64'd1 << ia; c_mc = 1;
        frame(mc_a, 10, 100, 0, 0);
        expect_dec("R9 extra bytes hash", 1, 1);
        c_mc = 0;
    endtask

    task automatic t_remote;  // R10
        c_atd = 1; c_mc = 1; table_v = '1;
        frame(mc_off, 6, 100, 0, 0);
        expect_dec("R10 off accepted", 1, 1);
        check("R10 disable pulse", tx_dis, 1);
        check("R10 no enable", tx_en, 0);
        @(negedge clk);
        check("R10 disable one cycle", tx_dis, 0);
        check("R10 decision held", accept, 1);
        c_mc = 0;
        frame(mc_on, 6, 20, 0, 0);
        expect_dec("R10 on rejected", 0, 1);
        check("R10 enable pulse", tx_en, 1);
        check("R10 no disable", tx_dis, 0);
        frame(mc_off, 6, 100, 1, 0);
        check("R10 errored no pulse", tx_dis, 0);
        c_atd = 0; c_mc = 1;
        frame(mc_off, 6, 100, 0, 0);
        check("R10 auto off no pulse", tx_dis, 0);
        check("R10 auto off accept", accept, 1);
        c_mc = 0; table_v = '0;
    endtask

    // Search for group addresses with known bins.
    task automatic find_addrs;
        int got = 0;
        int ib = -1;
        mc_off = '0; mc_on = '0; mc_a = '0; mc_b = '0; ia = -1;
        for (int k = 0; k < 4096; k++) begin
            logic [47:0] a;
            int b;
            a = {8'(k), 4'h0, 4'(k >> 8), 8'h00, 8'h5E, 8'h00, 8'h01};
            b = bin_of(a);
            if (b == 62 && mc_off == '0) mc_off = a;
            else if (b == 63 && mc_on == '0) mc_on = a;
            else if (b < 62 && ia < 0) begin ia = b; mc_a = a; end
            else if (b < 62 && ib < 0 && b != ia) begin ib = b; mc_b = a; end
        end
        got = (mc_off != '0) + (mc_on != '0) + (ib >= 0);
        n_checks++;
        if (got != 3) begin
            n_fail++;
            $display("FAIL R4 setup: got %0d addresses expected 3", got);
        end
    endtask

    initial begin
        find_addrs();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_unicast();
        t_promisc();
        t_bcast();
        t_mcast();
        t_runt();
        t_errors();
        t_timing();
        t_short();
        t_remote();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule